// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the byte-wide register front end of an eight-input programmable interrupt controller. Software reaches it through two byte addresses. Offset 0 carries the initialization start word and the operation command words. Offset 1 carries the rest of the initialization sequence and, outside that sequence, the interrupt mask. The block keeps the configuration that the priority core uses: the mask, the vector base, the cascade configuration, the trigger mode and the readback selection. It sends the core a one-cycle specific end-of-interrupt pulse that names a line. The core's pending and in-service registers come back on a read of offset 0.

Initialization takes two to four writes. The start word on offset 0 sets how many offset-1 writes follow. The vector base always follows. The cascade word follows only in cascade mode, and the mode word follows only when the start word asked for it. The meaning of each offset-1 write therefore depends on where the sequence stands. A static parameter sets whether the instance is a master or a slave. Rotation, special mask, buffering and the other end-of-interrupt forms are accepted but change nothing.

Top module: `pic_cfg_frontend`

## Requirements
- R1: After reset the mask, vector base, cascade configuration and trigger mode are all zero. The sequencer is idle, offset-0 reads select the pending register, and the end-of-interrupt strobe is low.
- R2: An offset-0 write with bit 4 set starts initialization. It clears the mask, sets the trigger mode output from bit 3 (1 = edge), selects cascade mode when bit 1 is 0, and records bit 0 as "mode word follows".
- R3: The first offset-1 write after the start word sets the vector base. Bits 2:0 of the stored base are always zero.
- R4: In single mode the vector-base write clears the cascade configuration. If no mode word is requested, the sequence ends there and the next offset-1 write loads the mask.
- R5: In cascade mode the offset-1 write after the vector base is the cascade word. A master (IS_MASTER=1) stores all 8 bits. A slave stores only bits 2:0, and its bits 7:3 read as zero.
- R6: When bit 0 of the start word was 1, one more offset-1 write (the mode word) is consumed after the vector base (single mode) or after the cascade word (cascade mode). It leaves the mask unchanged, and the sequencer then returns to idle.
- R7: While the sequencer is idle, an offset-1 write loads the mask with the written byte. With no write, the mask holds its value.
- R8: An offset-0 write with bits 4:3 = 00 and bits 7:5 = 3 raises the end-of-interrupt strobe for exactly one cycle, with the line taken from bits 2:0. Any other value of bits 7:5 raises no strobe.
- R9: An offset-0 write with bits 4:3 = 01 and bit 1 = 1 selects the offset-0 read source: bit 0 = 1 selects pending, bit 0 = 0 selects in-service. With bit 1 = 0 the selection is unchanged.
- R10: A read returns its data on the cycle after the read strobe. Offset 1 returns the mask, and offset 0 returns the selected core register.
- R11: A start word written in the middle of a sequence restarts the sequence from the vector-base step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 1 | Register offset (0 or 1) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after rd_en |
| pend_in | input | 8 | Pending register from the priority core |
| insvc_in | input | 8 | In-service register from the priority core |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, low 3 bits zero |
| casc_cfg_o | output | 8 | Slave map (master) or identity (slave) |
| edge_trig_o | output | 1 | 1 = edge triggered, 0 = level |
| casc_mode_o | output | 1 | 1 = cascade mode |
| eoi_stb_o | output | 1 | Specific end-of-interrupt pulse |
| eoi_line_o | output | 3 | Line named by the end-of-interrupt |

## Verification
Every configuration output changes on the clock edge that samples the write, so it is due one cycle after the write strobe. Read data follows the read strobe by one cycle, and the end-of-interrupt strobe is high in the single cycle after its command. The bench drives inputs on the falling edge and samples on the next falling edge. That places each check one cycle after its stimulus. For the strobe it also checks one cycle later, when the strobe must have dropped. Requirements that a write leaves something unchanged are checked by reading the mask or the cascade configuration after that write.

// File: rtl/pic_cfg_pkg.sv
package pic_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int NLINES = 8;
    localparam int LINE_W = $clog2(NLINES);

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_t;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_INIT,
        WK_CTL2,
        WK_CTL3
    } wk_t;

    localparam logic [2:0] SUB_SPEC_EOI = 3'd3;

    typedef struct packed {
        wk_t               kind;
        logic              eoi_hit;
        logic [LINE_W-1:0] eoi_line;
        logic              rdsel_upd;
        logic              rdsel_pend;
        logic              init_edge;
        logic              init_single;
        logic              init_want4;
    } cmd_t;

    function automatic wk_t classify(input logic [BYTE_W-1:0] b);
        if (b[4])              return WK_INIT;
        else if (b[4:3] == 2'b00) return WK_CTL2;
        else                   return WK_CTL3;
    endfunction
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
    import pic_cfg_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output cmd_t              cmd_o
);
    always_comb begin
        cmd_o             = '0;
        cmd_o.kind        = classify(byte_i);
        cmd_o.eoi_line    = byte_i[LINE_W-1:0];
        cmd_o.eoi_hit     = (cmd_o.kind == WK_CTL2) && (byte_i[7:5] == SUB_SPEC_EOI);
        cmd_o.rdsel_upd   = (cmd_o.kind == WK_CTL3) && byte_i[1];
        cmd_o.rdsel_pend  = byte_i[0];
        cmd_o.init_edge   = byte_i[3];
        cmd_o.init_single = byte_i[1];
        cmd_o.init_want4  = byte_i[0];
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cfg_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] byte_i,
    input  cmd_t              cmd_i,
    output logic [BYTE_W-1:0] mask_o,
    output logic [BYTE_W-1:0] vec_base_o,
    output logic [BYTE_W-1:0] casc_cfg_o,
    output logic              edge_o,
    output logic              casc_mode_o
);
    seq_t state;
    logic want4;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEQ_IDLE;
            want4       <= 1'b0;
            mask_o      <= '0;
            vec_base_o  <= '0;
            casc_cfg_o  <= '0;
            edge_o      <= 1'b0;
            casc_mode_o <= 1'b0;
        end else if (wr_cmd && cmd_i.kind == WK_INIT) begin
            state       <= SEQ_BASE;
            mask_o      <= '0;
            edge_o      <= cmd_i.init_edge;
            casc_mode_o <= !cmd_i.init_single;
            want4       <= cmd_i.init_want4;
        end else if (wr_data) begin
            unique case (state)
                SEQ_IDLE: mask_o <= byte_i;
                SEQ_BASE: begin
                    vec_base_o <= {byte_i[BYTE_W-1:LINE_W], {LINE_W{1'b0}}};
                    if (casc_mode_o) begin
                        state <= SEQ_CASC;
                    end else begin
                        casc_cfg_o <= '0;
                        state      <= want4 ? SEQ_MODE : SEQ_IDLE;
                    end
                end
                SEQ_CASC: begin
                    if (IS_MASTER)
                        casc_cfg_o <= byte_i;
                    else
                        casc_cfg_o <= {{(BYTE_W-LINE_W){1'b0}}, byte_i[LINE_W-1:0]};
                    state <= want4 ? SEQ_MODE : SEQ_IDLE;
                end
                SEQ_MODE: state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pic_rd_port.sv
module pic_rd_port
    import pic_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              addr,
    input  logic              sel_upd,
    input  logic              sel_pend,
    input  logic [BYTE_W-1:0] pend_in,
    input  logic [BYTE_W-1:0] insvc_in,
    input  logic [BYTE_W-1:0] mask_in,
    output logic [BYTE_W-1:0] rdata
);
    logic show_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            show_pend <= 1'b1;
            rdata     <= '0;
        end else begin
            if (sel_upd)
                show_pend <= sel_pend;
            if (rd_en)
                rdata <= addr ? mask_in : (show_pend ? pend_in : insvc_in);
        end
    end
endmodule

// File: rtl/pic_cfg_frontend.sv
module pic_cfg_frontend
    import pic_cfg_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [BYTE_W-1:0] pend_in,
    input  logic [BYTE_W-1:0] insvc_in,
    output logic [BYTE_W-1:0] mask_o,
    output logic [BYTE_W-1:0] vec_base_o,
    output logic [BYTE_W-1:0] casc_cfg_o,
    output logic              edge_trig_o,
    output logic              casc_mode_o,
    output logic              eoi_stb_o,
    output logic [LINE_W-1:0] eoi_line_o
);
    cmd_t cmd;
    logic wr_cmd, wr_data;

    assign wr_cmd  = wr_en && !addr;
    assign wr_data = wr_en && addr;

    pic_cmd_decode u_dec (
        .byte_i (wdata),
        .cmd_o  (cmd)
    );

    pic_init_seq #(.IS_MASTER(IS_MASTER)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_cmd      (wr_cmd),
        .wr_data     (wr_data),
        .byte_i      (wdata),
        .cmd_i       (cmd),
        .mask_o      (mask_o),
        .vec_base_o  (vec_base_o),
        .casc_cfg_o  (casc_cfg_o),
        .edge_o      (edge_trig_o),
        .casc_mode_o (casc_mode_o)
    );

    pic_rd_port u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (addr),
        .sel_upd  (wr_cmd && cmd.rdsel_upd),
        .sel_pend (cmd.rdsel_pend),
        .pend_in  (pend_in),
        .insvc_in (insvc_in),
        .mask_in  (mask_o),
        .rdata    (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            eoi_stb_o  <= 1'b0;
            eoi_line_o <= '0;
        end else begin
            eoi_stb_o <= wr_cmd && cmd.eoi_hit;
            if (wr_cmd && cmd.eoi_hit)
                eoi_line_o <= cmd.eoi_line;
        end
    end
endmodule

// File: rtl/pic_cfg_checker.sv
module pic_cfg_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] mask_o,
    input logic [7:0] vec_base_o,
    input logic       edge_trig_o,
    input logic       eoi_stb_o,
    input logic [2:0] eoi_line_o
);
    AST_EOI_CAUSE: assert property (@(posedge clk) disable iff (rst)
        eoi_stb_o |-> $past(wr_en && !addr && wdata[4:3] == 2'b00 && wdata[7:5] == 3'd3)); // R8
    AST_EOI_LINE: assert property (@(posedge clk) disable iff (rst)
        eoi_stb_o |-> eoi_line_o == $past(wdata[2:0])); // R8
    AST_INIT_CLEARS_MASK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4]) |=> (mask_o == 8'h00)); // R2
    AST_INIT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4]) |=> (edge_trig_o == $past(wdata[3]))); // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_o)); // R7
    AST_RD_MASK: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr) |=> (rdata == $past(mask_o))); // R10
    AST_BASE_VEC_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr) |=> $stable(vec_base_o)); // R3
endmodule

bind pic_cfg_frontend pic_cfg_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .mask_o      (mask_o),
    .vec_base_o  (vec_base_o),
    .edge_trig_o (edge_trig_o),
    .eoi_stb_o   (eoi_stb_o),
    .eoi_line_o  (eoi_line_o)
);

// File: tb/sim_pic_cfg_frontend.sv
module sim_pic_cfg_frontend;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PEND = 8'hA5;
    localparam logic [7:0] INSV = 8'h3C;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, mask_o, vec_o, casc_o;
    logic [7:0] rdata1, mask1, vec1, casc1;
    logic       edge_o, cmode_o, stb_o, edge1, cmode1, stb1;
    logic [2:0] line_o, line1;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_cfg_frontend #(.IS_MASTER(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pend_in(PEND), .insvc_in(INSV),
        .mask_o(mask_o), .vec_base_o(vec_o), .casc_cfg_o(casc_o),
        .edge_trig_o(edge_o), .casc_mode_o(cmode_o),
        .eoi_stb_o(stb_o), .eoi_line_o(line_o));

    pic_cfg_frontend #(.IS_MASTER(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata1), .pend_in(PEND), .insvc_in(INSV),
        .mask_o(mask1), .vec_base_o(vec1), .casc_cfg_o(casc1),
        .edge_trig_o(edge1), .casc_mode_o(cmode1),
        .eoi_stb_o(stb1), .eoi_line_o(line1));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 mask", mask_o, 8'h00);
        check("R1 base", vec_o, 8'h00);
        check("R1 casc", casc_o, 8'h00);
        check("R1 edge", {7'd0, edge_o}, 8'h00);
        check("R1 stb", {7'd0, stb_o}, 8'h00);
        rd(1'b0, d);
        check("R1 read select pending", d, PEND);
        wr(1'b1, 8'h81);
        check("R1 idle mask load", mask_o, 8'h81);
    endtask

    task automatic t_single_no4();
        logic [7:0] d;
        wr(1'b0, 8'h1A);
        check("R2 mask cleared", mask_o, 8'h00);
        check("R2 edge", {7'd0, edge_o}, 8'h01);
        check("R2 single", {7'd0, cmode_o}, 8'h00);
        wr(1'b1, 8'h27);
        check("R3 base low bits", vec_o, 8'h20);
        check("R4 casc cleared", casc_o, 8'h00);
        check("R4 mask untouched by base", mask_o, 8'h00);
        wr(1'b1, 8'h55);
        check("R4 sequence ended mask load", mask_o, 8'h55);
        rd(1'b1, d);
        check("R10 read mask", d, 8'h55);
    endtask

    task automatic t_cascade_4();
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h11);
        check("R2 mask cleared", mask_o, 8'h00);
        check("R2 level", {7'd0, edge_o}, 8'h00);
        check("R2 cascade", {7'd0, cmode_o}, 8'h01);
        wr(1'b1, 8'h4F);
        check("R3 base", vec_o, 8'h48);
        wr(1'b1, 8'h84);
        check("R5 master map", casc_o, 8'h84);
        check("R5 slave id", casc1, 8'h04);
        check("R5 mask untouched", mask_o, 8'h00);
        wr(1'b1, 8'h01);
        check("R6 mode word no mask", mask_o, 8'h00);
        check("R6 mode word no casc", casc_o, 8'h84);
        wr(1'b1, 8'h0F);
        check("R6 back to idle", mask_o, 8'h0F);
    endtask

    task automatic t_cascade_no4();
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h70);
        wr(1'b1, 8'h2E);
        check("R5 master map", casc_o, 8'h2E);
        check("R5 slave id", casc1, 8'h06);
        wr(1'b1, 8'h3C);
        check("R7 idle mask", mask_o, 8'h3C);
        check("R7 slave mask", mask1, 8'h3C);
    endtask

    task automatic t_single_4();
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h58);
        check("R4 casc cleared", casc_o, 8'h00);
        wr(1'b1, 8'hEE);
        check("R6 mode word no mask", mask_o, 8'h00);
        wr(1'b1, 8'hC3);
        check("R6 idle after mode", mask_o, 8'hC3);
    endtask

    task automatic t_eoi();
        wr(1'b0, 8'h65);
        check("R8 strobe high", {7'd0, stb_o}, 8'h01);
        check("R8 line", {5'd0, line_o}, 8'h05);
        @(negedge clk);
        check("R8 strobe one cycle", {7'd0, stb_o}, 8'h00);
        wr(1'b0, 8'h20);
        check("R8 nonspecific no strobe", {7'd0, stb_o}, 8'h00);
        wr(1'b0, 8'hC2);
        check("R8 code6 no strobe", {7'd0, stb_o}, 8'h00);
        wr(1'b0, 8'h62);
        check("R8 line 2", {5'd0, line_o}, 8'h02);
        check("R8 other cmd keeps mask", mask_o, 8'hC3);
    endtask

    task automatic t_rdsel();
        logic [7:0] d;
        wr(1'b0, 8'h0A);
        rd(1'b0, d);
        check("R9 select in-service", d, INSV);
        wr(1'b0, 8'h09);
        rd(1'b0, d);
        check("R9 bit1 clear keeps", d, INSV);
        wr(1'b0, 8'h0B);
        rd(1'b0, d);
        check("R9 select pending", d, PEND);
        rd(1'b1, d);
        check("R10 read mask", d, 8'hC3);
    endtask

    task automatic t_restart();
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h18);
        wr(1'b0, 8'h1A);
        check("R11 mask cleared", mask_o, 8'h00);
        wr(1'b1, 8'h90);
        check("R11 base step again", vec_o, 8'h90);
        check("R11 single casc clear", casc_o, 8'h00);
        wr(1'b1, 8'h42);
        check("R11 idle after restart", mask_o, 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_no4();
        t_cascade_4();
        t_cascade_no4();
        t_single_4();
        t_eoi();
        t_rdsel();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule